// File: doc/BRIEF.md
# Segmented Physical Address Generator

This block turns a request for a memory access into a 20-bit physical byte address. It holds the four segment bases (code, data, stack, extra) and the four offset pointers it maintains itself: the instruction pointer, the stack pointer and the two string index registers. Each request names what kind of access is needed, and for data accesses where the offset comes from. The block then picks the segment, forms the offset, and outputs `segment * 16 + offset`, truncated to 20 bits, one clock later.

The pointers update automatically as a side effect of the access. A push lowers the stack pointer by two before the address is formed, and a pop raises it by two afterwards. An instruction fetch advances the instruction pointer by the length the decoder reports. A string access steps its index up or down, by one for bytes and by two for words, as the direction input selects. A write port loads any register. Bus timing and segment override prefixes are handled elsewhere.

The control is a two-state machine. `ST_IDLE` means no result is presented. `ST_EMIT` means `out_valid` is high with the result of the request accepted on the previous edge. The transition `T_ACCEPT` moves from either state to `ST_EMIT` when a request with a legal kind is presented. The transition `T_DRAIN` moves from either state to `ST_IDLE` when no legal request is presented.

Top module: `seg_addr_gen`

## Requirements
- R1: After reset all eight registers are zero and `out_valid` is low, so the first fetch gives address 0x00000.
- R2: For an accepted request, `out_valid` is high in the following cycle. `out_addr` is then (segment << 4) + offset modulo 2^20, and `out_seg` gives the segment used (0 code, 1 data, 2 stack, 3 extra).
- R3: Kind 0 (fetch) uses code:IP. Afterwards IP increases by `req_ilen` (0..7), wrapping modulo 2^16.
- R4: Kind 1 (data) takes its offset from `req_src`, with every offset sum wrapping modulo 2^16. Source 0 is `req_disp` with the data segment. Source 1 is `req_base`+`req_disp` with the stack segment (frame-pointer based). Source 2 is SI+`req_disp` with the data segment. Source 3 is `req_base`+`req_disp` with the data segment.
- R5: Kind 2 (push) uses stack:(SP-2), and SP becomes SP-2.
- R6: Kind 3 (pop) uses stack:SP, and SP then becomes SP+2.
- R7: Kind 4 (string source) uses data:SI, and kind 5 (string destination) uses extra:DI. Afterwards the index moves by 1 (`str_word`=0) or 2 (`str_word`=1). It moves down when `dir_flag`=1 and up when `dir_flag`=0.
- R8: `wr_en` loads `wr_data` into the register `wr_sel` selects (0 code seg, 1 data seg, 2 stack seg, 3 extra seg, 4 IP, 5 SP, 6 SI, 7 DI). A request in the same cycle uses the old values. When both update the same register, the write wins.
- R9: Requests of kind 6 or 7 are ignored. They give no output and change no register.
- R10: `out_valid` is high exactly in the cycles that follow accepted requests, so back-to-back requests give back-to-back results, each seeing the pointer updates of the one before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_kind | input | 3 | Access kind (0..5 legal, 6..7 reserved) |
| req_src | input | 2 | Offset source for data accesses |
| req_base | input | 16 | Base register value supplied by the decoder |
| req_disp | input | 16 | Displacement |
| req_ilen | input | 3 | Bytes consumed by a fetch |
| str_word | input | 1 | String element is a word |
| dir_flag | input | 1 | String direction, 1 = downward |
| wr_en | input | 1 | Register write enable |
| wr_sel | input | 3 | Register written |
| wr_data | input | 16 | Write value |
| out_valid | output | 1 | Result present |
| out_addr | output | 20 | Physical byte address |
| out_seg | output | 2 | Segment used |

## Verification
The hardest situation to reach is a register write that collides with an automatic pointer update on the same edge. In that case the request must still see the old value while the write must survive. The stimulus creates it by issuing a push together with a write to SP, and a stack access together with a write to the stack segment. It then issues a pop, which shows the surviving SP at the port. A second hard case is the wrap of the 20-bit sum and of the 16-bit pointers. Directed loads put the code segment at 0xFFFF and the pointers next to zero before the accesses are issued. A long burst of random back-to-back requests then checks that each result sees the updates of the request before it.

// File: rtl/seg_pkg.sv
package seg_pkg;
    typedef enum logic [2:0] {
        K_FETCH = 3'd0,
        K_DATA  = 3'd1,
        K_PUSH  = 3'd2,
        K_POP   = 3'd3,
        K_SSRC  = 3'd4,
        K_SDST  = 3'd5,
        K_RSV6  = 3'd6,
        K_RSV7  = 3'd7
    } acc_kind_t;

    typedef enum logic [1:0] {
        O_DISP  = 2'd0,
        O_BPREL = 2'd1,
        O_SIREL = 2'd2,
        O_BASE  = 2'd3
    } ofs_src_t;

    typedef enum logic [1:0] {
        SG_CS = 2'd0,
        SG_DS = 2'd1,
        SG_SS = 2'd2,
        SG_ES = 2'd3
    } seg_id_t;

    localparam int NREG  = 8;
    localparam int RI_CS = 0;
    localparam int RI_DS = 1;
    localparam int RI_SS = 2;
    localparam int RI_ES = 3;
    localparam int RI_IP = 4;
    localparam int RI_SP = 5;
    localparam int RI_SI = 6;
    localparam int RI_DI = 7;
endpackage

// File: rtl/seg_regfile.sv
module seg_regfile
    import seg_pkg::*;
#(
    parameter int REG_W  = 16,
    parameter int ILEN_W = 3,
    parameter int SEL_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              upd_en_i,
    input  acc_kind_t         upd_kind_i,
    input  logic [ILEN_W-1:0] ilen_i,
    input  logic              str_word_i,
    input  logic              dir_i,
    input  logic              wr_en_i,
    input  logic [SEL_W-1:0]  wr_sel_i,
    input  logic [REG_W-1:0]  wr_data_i,
    output logic [REG_W-1:0]  cs_o,
    output logic [REG_W-1:0]  ds_o,
    output logic [REG_W-1:0]  ss_o,
    output logic [REG_W-1:0]  es_o,
    output logic [REG_W-1:0]  ip_o,
    output logic [REG_W-1:0]  sp_o,
    output logic [REG_W-1:0]  si_o,
    output logic [REG_W-1:0]  di_o
);
    localparam logic [REG_W-1:0] STK_STEP = REG_W'(2);

    logic [REG_W-1:0] r_q [NREG];
    logic [REG_W-1:0] r_d [NREG];
    logic [REG_W-1:0] str_step;

    assign str_step = str_word_i ? REG_W'(2) : REG_W'(1);

    always_comb begin
        for (int i = 0; i < NREG; i++) r_d[i] = r_q[i];
        if (upd_en_i) begin
            unique case (upd_kind_i)
                K_FETCH: r_d[RI_IP] = r_q[RI_IP] + REG_W'(ilen_i);
                K_PUSH:  r_d[RI_SP] = r_q[RI_SP] - STK_STEP;
                K_POP:   r_d[RI_SP] = r_q[RI_SP] + STK_STEP;
                K_SSRC:  r_d[RI_SI] = dir_i ? r_q[RI_SI] - str_step
                                            : r_q[RI_SI] + str_step;
                K_SDST:  r_d[RI_DI] = dir_i ? r_q[RI_DI] - str_step
                                            : r_q[RI_DI] + str_step;
                default: ;
            endcase
        end
        if (wr_en_i) r_d[wr_sel_i] = wr_data_i;
    end

    for (genvar g = 0; g < NREG; g++) begin : g_reg
        always_ff @(posedge clk) begin
            if (!rst_n) r_q[g] <= '0;
            else        r_q[g] <= r_d[g];
        end
    end

    assign cs_o = r_q[RI_CS];
    assign ds_o = r_q[RI_DS];
    assign ss_o = r_q[RI_SS];
    assign es_o = r_q[RI_ES];
    assign ip_o = r_q[RI_IP];
    assign sp_o = r_q[RI_SP];
    assign si_o = r_q[RI_SI];
    assign di_o = r_q[RI_DI];

    // R5
    sp_push_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_en_i && upd_kind_i == K_PUSH && !(wr_en_i && wr_sel_i == SEL_W'(RI_SP)))
        |=> sp_o == $past(sp_o) - STK_STEP);

    // R6
    sp_pop_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_en_i && upd_kind_i == K_POP && !(wr_en_i && wr_sel_i == SEL_W'(RI_SP)))
        |=> sp_o == $past(sp_o) + STK_STEP);

    // R8
    wr_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_i |=> r_q[$past(wr_sel_i)] == $past(wr_data_i));

    // R7
    si_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_en_i && upd_kind_i == K_SSRC && dir_i && !str_word_i
         && !(wr_en_i && wr_sel_i == SEL_W'(RI_SI)))
        |=> si_o + REG_W'(1) == $past(si_o));
endmodule

// File: rtl/seg_select.sv
module seg_select
    import seg_pkg::*;
#(
    parameter int REG_W = 16
) (
    input  acc_kind_t        kind_i,
    input  ofs_src_t         src_i,
    input  logic [REG_W-1:0] base_i,
    input  logic [REG_W-1:0] disp_i,
    input  logic [REG_W-1:0] cs_i,
    input  logic [REG_W-1:0] ds_i,
    input  logic [REG_W-1:0] ss_i,
    input  logic [REG_W-1:0] es_i,
    input  logic [REG_W-1:0] ip_i,
    input  logic [REG_W-1:0] sp_i,
    input  logic [REG_W-1:0] si_i,
    input  logic [REG_W-1:0] di_i,
    output seg_id_t          seg_id_o,
    output logic [REG_W-1:0] seg_val_o,
    output logic [REG_W-1:0] off_o
);
    always_comb begin
        seg_id_o = SG_DS;
        off_o    = disp_i;
        unique case (kind_i)
            K_FETCH: begin seg_id_o = SG_CS; off_o = ip_i; end
            K_DATA: begin
                unique case (src_i)
                    O_DISP:  begin seg_id_o = SG_DS; off_o = disp_i; end
                    O_BPREL: begin seg_id_o = SG_SS; off_o = base_i + disp_i; end
                    O_SIREL: begin seg_id_o = SG_DS; off_o = si_i + disp_i; end
                    O_BASE:  begin seg_id_o = SG_DS; off_o = base_i + disp_i; end
                    default: ;
                endcase
            end
            K_PUSH:  begin seg_id_o = SG_SS; off_o = sp_i - REG_W'(2); end
            K_POP:   begin seg_id_o = SG_SS; off_o = sp_i; end
            K_SSRC:  begin seg_id_o = SG_DS; off_o = si_i; end
            K_SDST:  begin seg_id_o = SG_ES; off_o = di_i; end
            default: ;
        endcase
    end

    always_comb begin
        unique case (seg_id_o)
            SG_CS:   seg_val_o = cs_i;
            SG_DS:   seg_val_o = ds_i;
            SG_SS:   seg_val_o = ss_i;
            SG_ES:   seg_val_o = es_i;
            default: seg_val_o = ds_i;
        endcase
    end
endmodule

// File: rtl/seg_adder.sv
module seg_adder #(
    parameter int REG_W  = 16,
    parameter int ADDR_W = 20
) (
    input  logic [REG_W-1:0]  seg_i,
    input  logic [REG_W-1:0]  off_i,
    output logic [ADDR_W-1:0] phys_o
);
    localparam int SHIFT = ADDR_W - REG_W;

    logic [ADDR_W-1:0] seg_ext;
    logic [ADDR_W-1:0] off_ext;

    assign seg_ext = ADDR_W'(seg_i) << SHIFT;
    assign off_ext = ADDR_W'(off_i);
    assign phys_o  = seg_ext + off_ext;

    // R2
    always_comb begin
        if (!$isunknown({seg_i, off_i}))
            low_bits_chk: assert (phys_o[SHIFT-1:0] == off_i[SHIFT-1:0]);
    end
endmodule

// File: rtl/seg_addr_gen.sv
module seg_addr_gen
    import seg_pkg::*;
#(
    parameter int REG_W  = 16,
    parameter int ADDR_W = 20,
    parameter int ILEN_W = 3,
    parameter int KIND_W = 3,
    parameter int SEL_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [KIND_W-1:0] req_kind,
    input  logic [1:0]        req_src,
    input  logic [REG_W-1:0]  req_base,
    input  logic [REG_W-1:0]  req_disp,
    input  logic [ILEN_W-1:0] req_ilen,
    input  logic              str_word,
    input  logic              dir_flag,
    input  logic              wr_en,
    input  logic [SEL_W-1:0]  wr_sel,
    input  logic [REG_W-1:0]  wr_data,
    output logic              out_valid,
    output logic [ADDR_W-1:0] out_addr,
    output logic [1:0]        out_seg
);
    typedef enum logic {ST_IDLE, ST_EMIT} st_t;

    st_t              st_q, st_d;
    acc_kind_t        kind;
    logic             accept;
    logic [REG_W-1:0] cs, ds, ss, es, ip, sp, si, di;
    seg_id_t          sel_id;
    logic [REG_W-1:0] sel_seg, sel_off;
    logic [ADDR_W-1:0] phys;

    assign kind   = acc_kind_t'(req_kind);
    assign accept = req_valid && (kind != K_RSV6) && (kind != K_RSV7);

    seg_regfile #(.REG_W(REG_W), .ILEN_W(ILEN_W), .SEL_W(SEL_W)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .upd_en_i(accept), .upd_kind_i(kind), .ilen_i(req_ilen),
        .str_word_i(str_word), .dir_i(dir_flag),
        .wr_en_i(wr_en), .wr_sel_i(wr_sel), .wr_data_i(wr_data),
        .cs_o(cs), .ds_o(ds), .ss_o(ss), .es_o(es),
        .ip_o(ip), .sp_o(sp), .si_o(si), .di_o(di)
    );

    seg_select #(.REG_W(REG_W)) u_sel (
        .kind_i(kind), .src_i(ofs_src_t'(req_src)),
        .base_i(req_base), .disp_i(req_disp),
        .cs_i(cs), .ds_i(ds), .ss_i(ss), .es_i(es),
        .ip_i(ip), .sp_i(sp), .si_i(si), .di_i(di),
        .seg_id_o(sel_id), .seg_val_o(sel_seg), .off_o(sel_off)
    );

    seg_adder #(.REG_W(REG_W), .ADDR_W(ADDR_W)) u_add (
        .seg_i(sel_seg), .off_i(sel_off), .phys_o(phys)
    );

    // next-state: T_ACCEPT / T_DRAIN
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE: st_d = accept ? ST_EMIT : ST_IDLE;
            ST_EMIT: st_d = accept ? ST_EMIT : ST_IDLE;
            default: st_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_addr <= '0;
            out_seg  <= '0;
        end else if (accept) begin
            out_addr <= phys;
            out_seg  <= sel_id;
        end
    end

    assign out_valid = (st_q == ST_EMIT);

    // R9
    bad_kind_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_kind >= KIND_W'(6)) |=> !out_valid);

    // R9
    bad_kind_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_kind >= KIND_W'(6) && !wr_en)
        |=> $stable({cs, ds, ss, es, ip, sp, si, di}));

    // R3
    fetch_code_seg_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_kind == KIND_W'(0)) |=> out_seg == 2'd0);

    // R5
    push_stack_seg_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_kind == KIND_W'(2)) |=> out_seg == 2'd2);

    // R10
    idle_after_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !out_valid);
endmodule

// File: tb/sim_seg_addr_gen.sv
module sim_seg_addr_gen;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [2:0]  req_kind = '0;
    logic [1:0]  req_src = '0;
    logic [15:0] req_base = '0;
    logic [15:0] req_disp = '0;
    logic [2:0]  req_ilen = '0;
    logic        str_word = 1'b0;
    logic        dir_flag = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_sel = '0;
    logic [15:0] wr_data = '0;
    logic        out_valid;
    logic [19:0] out_addr;
    logic [1:0]  out_seg;

    always #2 clk = ~clk;

    seg_addr_gen u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind),
        .req_src(req_src), .req_base(req_base), .req_disp(req_disp),
        .req_ilen(req_ilen), .str_word(str_word), .dir_flag(dir_flag),
        .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .out_valid(out_valid), .out_addr(out_addr), .out_seg(out_seg)
    );

    typedef struct {
        logic [19:0] a;
        logic [1:0]  sg;
        string       tag;
    } exp_t;

    exp_t        q[$];
    logic [15:0] m [8];
    int          n_run = 0;
    int          n_fail = 0;
    string       idle_tag = "R10";
    bit          done = 0;

    task automatic note(input bit ok, input string tag, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic cyc(input bit v, input logic [2:0] k, input logic [1:0] s,
                       input logic [15:0] b, input logic [15:0] d,
                       input logic [2:0] il, input bit w, input bit dr,
                       input bit we, input logic [2:0] ws, input logic [15:0] wd,
                       input string tag);
        logic [15:0] off, segv, st;
        logic [1:0]  sg;
        bit          acc;
        @(negedge clk);
        req_valid = v; req_kind = k; req_src = s; req_base = b; req_disp = d;
        req_ilen = il; str_word = w; dir_flag = dr;
        wr_en = we; wr_sel = ws; wr_data = wd;
        acc = v && (k <= 3'd5);
        idle_tag = tag;
        st = w ? 16'd2 : 16'd1;
        if (acc) begin
            sg = 2'd1; off = d;
            case (k)
                3'd0: begin sg = 2'd0; off = m[4]; end
                3'd1: case (s)
                    2'd0: begin sg = 2'd1; off = d; end
                    2'd1: begin sg = 2'd2; off = b + d; end
                    2'd2: begin sg = 2'd1; off = m[6] + d; end
                    default: begin sg = 2'd1; off = b + d; end
                endcase
                3'd2: begin sg = 2'd2; off = m[5] - 16'd2; end
                3'd3: begin sg = 2'd2; off = m[5]; end
                3'd4: begin sg = 2'd1; off = m[6]; end
                default: begin sg = 2'd3; off = m[7]; end
            endcase
            segv = m[sg];
            q.push_back('{a: ({4'h0, segv} << 4) + {4'h0, off}, sg: sg, tag: tag});
            case (k)
                3'd0: m[4] = m[4] + {13'd0, il};
                3'd2: m[5] = m[5] - 16'd2;
                3'd3: m[5] = m[5] + 16'd2;
                3'd4: m[6] = dr ? m[6] - st : m[6] + st;
                3'd5: m[7] = dr ? m[7] - st : m[7] + st;
                default: ;
            endcase
        end
        if (we) m[ws] = wd;
    endtask

    task automatic rq(input logic [2:0] k, input logic [1:0] s, input logic [15:0] b,
                      input logic [15:0] d, input logic [2:0] il, input bit w,
                      input bit dr, input string tag);
        cyc(1'b1, k, s, b, d, il, w, dr, 1'b0, 3'd0, 16'd0, tag);
    endtask

    task automatic wr(input logic [2:0] ws, input logic [15:0] wd);
        cyc(1'b0, 3'd0, 2'd0, 16'd0, 16'd0, 3'd0, 1'b0, 1'b0, 1'b1, ws, wd, "R8");
    endtask

    task automatic idle(input string tag);
        cyc(1'b0, 3'd0, 2'd0, 16'd0, 16'd0, 3'd0, 1'b0, 1'b0, 1'b0, 3'd0, 16'd0, tag);
    endtask

    // scoreboard monitor
    always @(posedge clk) begin
        #1;
        if (rst_n && !done) begin
            if (q.size() > 0) begin
                exp_t e;
                e = q.pop_front();
                note(out_valid === 1'b1, e.tag, "out_valid", {31'd0, out_valid}, 32'd1);
                note(out_addr === e.a && out_seg === e.sg, e.tag, "addr/seg",
                     {10'd0, out_seg, out_addr}, {10'd0, e.sg, e.a});
            end else begin
                note(out_valid === 1'b0, idle_tag, "unexpected out_valid",
                     {31'd0, out_valid}, 32'd0);
            end
        end
    end

    initial begin
        #400000;
        if (!done) begin
            done = 1;
            n_run++; n_fail++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 8; i++) m[i] = 16'd0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        note(out_valid === 1'b0, "R1", "out_valid after reset", {31'd0, out_valid}, 32'd0);
        // R1 R3: first fetch from zeroed registers
        rq(3'd0, 2'd0, 16'd0, 16'd0, 3'd3, 1'b0, 1'b0, "R1");
        idle("R10");
        // R8 loads
        wr(3'd0, 16'hF000); wr(3'd4, 16'hFFF0); wr(3'd1, 16'h1234);
        wr(3'd2, 16'h2000); wr(3'd3, 16'h3000); wr(3'd5, 16'h0100);
        wr(3'd6, 16'h0010); wr(3'd7, 16'h0020);
        // R3 fetch stream with IP wrap
        rq(3'd0, 2'd0, 16'd0, 16'd0, 3'd5, 1'b0, 1'b0, "R3");
        rq(3'd0, 2'd0, 16'd0, 16'd0, 3'd4, 1'b0, 1'b0, "R3");
        rq(3'd0, 2'd0, 16'd0, 16'd0, 3'd7, 1'b0, 1'b0, "R3");
        rq(3'd0, 2'd0, 16'd0, 16'd0, 3'd0, 1'b0, 1'b0, "R3");
        // R2 20-bit wrap
        wr(3'd0, 16'hFFFF); wr(3'd4, 16'h0020);
        rq(3'd0, 2'd0, 16'd0, 16'd0, 3'd1, 1'b0, 1'b0, "R2");
        // R4 data sources
        rq(3'd1, 2'd0, 16'h0000, 16'h0005, 3'd0, 1'b0, 1'b0, "R4");
        rq(3'd1, 2'd1, 16'hFFFE, 16'h0004, 3'd0, 1'b0, 1'b0, "R4");
        rq(3'd1, 2'd2, 16'h0000, 16'h0003, 3'd0, 1'b0, 1'b0, "R4");
        rq(3'd1, 2'd3, 16'h0100, 16'h0010, 3'd0, 1'b0, 1'b0, "R4");
        // R5 R6 stack
        rq(3'd2, 2'd0, 16'd0, 16'd0, 3'd0, 1'b0, 1'b0, "R5");
        rq(3'd2, 2'd0, 16'd0, 16'd0, 3'd0, 1'b0, 1'b0, "R5");
        rq(3'd3, 2'd0, 16'd0, 16'd0, 3'd0, 1'b0, 1'b0, "R6");
        rq(3'd3, 2'd0, 16'd0, 16'd0, 3'd0, 1'b0, 1'b0, "R6");
        wr(3'd5, 16'h0000);
        rq(3'd2, 2'd0, 16'd0, 16'd0, 3'd0, 1'b0, 1'b0, "R5");
        rq(3'd3, 2'd0, 16'd0, 16'd0, 3'd0, 1'b0, 1'b0, "R6");
        // R7 strings
        rq(3'd4, 2'd0, 16'd0, 16'd0, 3'd0, 1'b0, 1'b0, "R7");
        rq(3'd4, 2'd0, 16'd0, 16'd0, 3'd0, 1'b1, 1'b0, "R7");
        rq(3'd4, 2'd0, 16'd0, 16'd0, 3'd0, 1'b1, 1'b1, "R7");
        rq(3'd4, 2'd0, 16'd0, 16'd0, 3'd0, 1'b0, 1'b1, "R7");
        rq(3'd4, 2'd0, 16'd0, 16'd0, 3'd0, 1'b0, 1'b0, "R7");
        rq(3'd5, 2'd0, 16'd0, 16'd0, 3'd0, 1'b1, 1'b0, "R7");
        rq(3'd5, 2'd0, 16'd0, 16'd0, 3'd0, 1'b0, 1'b1, "R7");
        rq(3'd5, 2'd0, 16'd0, 16'd0, 3'd0, 1'b1, 1'b1, "R7");
        rq(3'd5, 2'd0, 16'd0, 16'd0, 3'd0, 1'b0, 1'b0, "R7");
        // R9 reserved kinds ignored; state shown by the next requests
        rq(3'd6, 2'd0, 16'd0, 16'd0, 3'd7, 1'b1, 1'b0, "R9");
        rq(3'd7, 2'd0, 16'd0, 16'd0, 3'd7, 1'b1, 1'b1, "R9");
        idle("R9");
        rq(3'd2, 2'd0, 16'd0, 16'd0, 3'd0, 1'b0, 1'b0, "R9");
        rq(3'd4, 2'd0, 16'd0, 16'd0, 3'd0, 1'b0, 1'b0, "R9");
        rq(3'd0, 2'd0, 16'd0, 16'd0, 3'd0, 1'b0, 1'b0, "R9");
        // R8 collisions: write wins, request sees old value
        cyc(1'b1, 3'd2, 2'd0, 16'd0, 16'd0, 3'd0, 1'b0, 1'b0, 1'b1, 3'd5, 16'h0400, "R8");
        rq(3'd3, 2'd0, 16'd0, 16'd0, 3'd0, 1'b0, 1'b0, "R8");
        cyc(1'b1, 3'd3, 2'd0, 16'd0, 16'd0, 3'd0, 1'b0, 1'b0, 1'b1, 3'd2, 16'h5000, "R8");
        rq(3'd3, 2'd0, 16'd0, 16'd0, 3'd0, 1'b0, 1'b0, "R8");
        cyc(1'b1, 3'd4, 2'd0, 16'd0, 16'd0, 3'd0, 1'b1, 1'b0, 1'b1, 3'd6, 16'h0777, "R8");
        rq(3'd4, 2'd0, 16'd0, 16'd0, 3'd0, 1'b0, 1'b0, "R8");
        idle("R10");
        // R10 random back-to-back traffic
        for (int i = 0; i < 400; i++) begin
            logic [31:0] r;
            r = $urandom;
            if (r[31:29] == 3'd0)
                cyc(r[0], r[3:1], r[5:4], r[21:6], r[27:12], r[8:6], r[9], r[10],
                    1'b1, r[13:11], r[28:13], "R10");
            else if (r[31:28] == 4'd15)
                idle("R10");
            else
                rq(r[2:0], r[4:3], r[20:5], r[26:11], r[7:5], r[8], r[9], "R10");
        end
        repeat (3) idle("R10");
        @(negedge clk);
        note(q.size() == 0, "R10", "pending results", q.size(), 0);
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule